// File: doc/BRIEF.md
# Paged CSR Viewport Bridge

This block is an APB3 slave that lets a host reach a 21-bit space of 16-bit control and status registers. Each internal address is a 5-bit device number (bits 20:16) above a 16-bit register number (bits 15:0). The block drives a plain register port: an address, a one-cycle write strobe, write data, and combinational read data returned from the register file.

Two compile-time choices shape the bus view. In direct mode (`INDIRECT = 0`) the whole register space is mapped linearly, with one bus word per register. In paged mode (`INDIRECT = 1`) only a 256-word window is visible. The top word of that window holds a 13-bit page register, which supplies internal address bits 20:8. The other 255 words reach the registers of the current page. `WORD_BYTES` sets the bus word spacing to 2 or 4 bytes. It also sets the data width of the bus.

A small phase machine tracks the APB handshake. It has two states. `PH_IDLE` means no setup phase was seen in the previous cycle. `PH_ARMED` means the previous cycle was a setup phase, so the current cycle is the access phase. The machine has three transitions. "setup seen" goes from `PH_IDLE` to `PH_ARMED` when `psel` is high and `penable` is low. "access done" goes from `PH_ARMED` back to `PH_IDLE` unconditionally. "stay idle" keeps `PH_IDLE` in every other case. Every transfer completes in its access cycle with `pready` high.

Top module: `csr_page_bridge`

## Requirements
- R1: In paged mode, window word 0xFF is the page register. It resets to 0. A write stores `pwdata[12:0]` and ignores `pwdata[15:13]`. A read returns the page zero-extended. A page access never pulses `csr_wr`.
- R2: In paged mode, an access to window word `o` (0x00..0xFE) drives `csr_addr = {page, o[7:0]}`.
- R3: The page value changes only on an in-window write to word 0xFF. Data accesses, failed accesses and ignored cycles leave it unchanged.
- R4: In direct mode, `csr_addr` equals the 21-bit word index.
- R5: The word index is `paddr >> 1` when `WORD_BYTES = 2` and `paddr >> 2` when `WORD_BYTES = 4`. Byte-offset bits below the word are ignored.
- R6: With `WORD_BYTES = 4`, `pwdata[31:16]` is ignored and `prdata[31:16]` reads as zero.
- R7: A word index at or above the window size (256 in paged mode, 2^21 in direct mode) raises `pslverr` in the access cycle. It pulses no `csr_wr`, leaves `prdata` at zero and does not touch the page register.
- R8: An in-window data write pulses `csr_wr` for exactly the access cycle, with `csr_wdata = pwdata[15:0]`. `pready` is high in every access cycle.
- R9: An in-window read returns the selected register on `prdata` combinationally in the access cycle. During a write cycle `prdata` is zero.
- R10: A cycle with `psel` and `penable` both high that does not follow a setup cycle is ignored: no `csr_wr` and no `pslverr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | PADDR_W | Byte address |
| pwdata | input | WORD_BYTES*8 | Bus write data |
| prdata | output | WORD_BYTES*8 | Bus read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Out-of-window error |
| csr_addr | output | 21 | Internal register address |
| csr_wr | output | 1 | Internal write strobe |
| csr_wdata | output | 16 | Internal write data |
| csr_rdata | input | 16 | Internal read data |

## Verification
The assertions assume an APB master that follows the protocol. A write strobe therefore always follows a setup cycle, and `penable` never rises while a transfer is already in its access cycle. The stimulus holds every input steady across setup and access, and it drives only at falling edges. The one deliberate protocol violation is a lone access cycle with no setup before it. It is issued from the idle state, where the R10 assertion permits it. The register file is modeled as a pure function of `csr_addr`, so read data is always defined.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
    localparam int REG_ADDR_W  = 21;
    localparam int REG_DATA_W  = 16;
    localparam int WIN_OFS_W   = 8;
    localparam int PAGE_W      = REG_ADDR_W - WIN_OFS_W;
    localparam logic [WIN_OFS_W-1:0] PAGE_SLOT = '1;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } apb_phase_e;
endpackage

// File: rtl/csr_apb_fsm.sv
module csr_apb_fsm
    import csr_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic access_o
);
    apb_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  if (psel && !penable) state_d = PH_ARMED;
            PH_ARMED: state_d = PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        access_o = (state_q == PH_ARMED) && psel && penable;
    end

    assert_access_after_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        access_o |-> $past(psel && !penable));

    assert_access_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        access_o |=> !access_o);
endmodule

// File: rtl/csr_win_decode.sv
module csr_win_decode
    import csr_bridge_pkg::*;
#(
    parameter bit INDIRECT   = 1'b1,
    parameter int WORD_SHIFT = 2,
    parameter int PADDR_W    = 24
) (
    input  logic [PADDR_W-1:0]    paddr,
    input  logic [PAGE_W-1:0]     page_q,
    output logic [REG_ADDR_W-1:0] reg_addr,
    output logic                  in_range,
    output logic                  hit_page
);
    logic [PADDR_W-1:0] word_idx;
    assign word_idx = paddr >> WORD_SHIFT;

    generate
        if (INDIRECT) begin : g_paged
            logic [WIN_OFS_W-1:0] ofs;
            assign ofs      = word_idx[WIN_OFS_W-1:0];
            assign in_range = (word_idx >> WIN_OFS_W) == '0;
            assign hit_page = in_range && (ofs == PAGE_SLOT);
            assign reg_addr = {page_q, ofs};
        end else begin : g_linear
            logic unused_page;
            assign unused_page = ^page_q;
            assign in_range = (word_idx >> REG_ADDR_W) == '0;
            assign hit_page = 1'b0;
            assign reg_addr = REG_ADDR_W'(word_idx);
        end
    endgenerate
endmodule

// File: rtl/csr_page_reg.sv
module csr_page_reg
    import csr_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0]     page_o
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[REG_DATA_W-1:PAGE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  page_o <= '0;
        else if (we) page_o <= wdata[PAGE_W-1:0];
    end

    assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page_o));

    assert_page_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> page_o == $past(wdata[PAGE_W-1:0]));
endmodule

// File: rtl/csr_page_bridge.sv
module csr_page_bridge
    import csr_bridge_pkg::*;
#(
    parameter bit INDIRECT   = 1'b1,
    parameter int WORD_BYTES = 4,
    parameter int PADDR_W    = 24,
    localparam int DATA_W    = WORD_BYTES * 8,
    localparam int WORD_SHIFT = (WORD_BYTES == 4) ? 2 : 1
) (
    input  logic                  pclk,
    input  logic                  presetn,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [PADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]     pwdata,
    output logic [DATA_W-1:0]     prdata,
    output logic                  pready,
    output logic                  pslverr,
    output logic [REG_ADDR_W-1:0] csr_addr,
    output logic                  csr_wr,
    output logic [REG_DATA_W-1:0] csr_wdata,
    input  logic [REG_DATA_W-1:0] csr_rdata
);
    logic              access;
    logic              in_range;
    logic              hit_page;
    logic [PAGE_W-1:0] page_q;
    logic [REG_DATA_W-1:0] rd_word;

    csr_apb_fsm u_fsm (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .access_o (access)
    );

    csr_win_decode #(
        .INDIRECT   (INDIRECT),
        .WORD_SHIFT (WORD_SHIFT),
        .PADDR_W    (PADDR_W)
    ) u_dec (
        .paddr    (paddr),
        .page_q   (page_q),
        .reg_addr (csr_addr),
        .in_range (in_range),
        .hit_page (hit_page)
    );

    generate
        if (INDIRECT) begin : g_page
            csr_page_reg u_page (
                .clk    (pclk),
                .rst_n  (presetn),
                .we     (access && pwrite && hit_page),
                .wdata  (pwdata[REG_DATA_W-1:0]),
                .page_o (page_q)
            );
        end else begin : g_nopage
            assign page_q = '0;
        end

        if (DATA_W > REG_DATA_W) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^pwdata[DATA_W-1:REG_DATA_W];
        end
    endgenerate

    always_comb begin
        rd_word   = hit_page ? REG_DATA_W'(page_q) : csr_rdata;
        csr_wdata = pwdata[REG_DATA_W-1:0];
        csr_wr    = access && pwrite && in_range && !hit_page;
        pslverr   = access && !in_range;
        pready    = 1'b1;
        prdata    = (access && !pwrite && in_range) ? DATA_W'(rd_word) : '0;
    end

    assert_err_no_strobe_R7: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> !csr_wr);

    assert_strobe_is_write_R8: assert property (@(posedge pclk) disable iff (!presetn)
        csr_wr |-> (psel && penable && pwrite));

    assert_strobe_one_cycle_R8: assert property (@(posedge pclk) disable iff (!presetn)
        csr_wr |=> !csr_wr);

    assert_rdata_idle_zero_R9: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable) |-> prdata == '0);
endmodule

// File: tb/csr_page_bridge_tb.sv
`timescale 1ns/1ps
module csr_page_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel_i = 1'b0, psel_d = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [23:0] paddr = '0;
    logic [31:0] pwdata = '0;

    logic [31:0] prdata_i;
    logic [15:0] prdata_d;
    logic        pready_i, pready_d, pslverr_i, pslverr_d, wr_i, wr_d;
    logic [20:0] addr_i, addr_d;
    logic [15:0] wd_i, wd_d, rd_i, rd_d;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [31:0] s_rd;
    logic        s_err, s_wr, s_rdy, s_post;
    logic [20:0] s_addr;
    logic [15:0] s_wd;

    always #4 clk = ~clk;

    function automatic logic [15:0] model(input logic [20:0] a);
        return a[15:0] ^ {a[20:16], 11'd0};
    endfunction

    assign rd_i = model(addr_i);
    assign rd_d = model(addr_d);

    csr_page_bridge #(.INDIRECT(1'b1), .WORD_BYTES(4), .PADDR_W(12)) u_dut (
        .pclk(clk), .presetn(rst_n), .psel(psel_i), .penable(penable),
        .pwrite(pwrite), .paddr(paddr[11:0]), .pwdata(pwdata),
        .prdata(prdata_i), .pready(pready_i), .pslverr(pslverr_i),
        .csr_addr(addr_i), .csr_wr(wr_i), .csr_wdata(wd_i), .csr_rdata(rd_i));

    csr_page_bridge #(.INDIRECT(1'b0), .WORD_BYTES(2), .PADDR_W(24)) u_dut_dir (
        .pclk(clk), .presetn(rst_n), .psel(psel_d), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata[15:0]),
        .prdata(prdata_d), .pready(pready_d), .pslverr(pslverr_d),
        .csr_addr(addr_d), .csr_wr(wr_d), .csr_wdata(wd_d), .csr_rdata(rd_d));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic grab(input bit dir);
        if (dir) begin
            s_rd = {16'd0, prdata_d}; s_err = pslverr_d; s_wr = wr_d;
            s_addr = addr_d; s_wd = wd_d; s_rdy = pready_d;
        end else begin
            s_rd = prdata_i; s_err = pslverr_i; s_wr = wr_i;
            s_addr = addr_i; s_wd = wd_i; s_rdy = pready_i;
        end
    endtask

    task automatic xfer(input bit dir, input logic [23:0] a, input bit wr, input logic [31:0] wd);
        @(negedge clk);
        psel_i = !dir; psel_d = dir; penable = 1'b0;
        paddr = a; pwrite = wr; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #1 grab(dir);
        @(negedge clk);
        psel_i = 1'b0; psel_d = 1'b0; penable = 1'b0;
        #1 s_post = dir ? wr_d : wr_i;
    endtask

    task automatic set_page(input logic [12:0] p);
        xfer(1'b0, 24'h3FC, 1'b1, {16'hBEEF, 3'b111, p});
        chk("R1 page write no strobe", {31'd0, s_wr}, 32'd0);
    endtask

    task automatic read_page(input logic [12:0] p, input string req);
        xfer(1'b0, 24'h3FC, 1'b0, 32'd0);
        chk(req, s_rd, {19'd0, p});
    endtask

    initial begin : main
        logic [12:0] pages [5];
        pages = '{13'h0000, 13'h0001, 13'h00A5, 13'h1FFF, 13'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_page(13'h0, "R1 reset page");
        chk("R8 pready", {31'd0, s_rdy}, 32'd1);

        foreach (pages[k]) begin
            set_page(pages[k]);
            read_page(pages[k], "R1 page readback");
            for (int o = 0; o < 255; o++) begin
                xfer(1'b0, 24'(o << 2), 1'b0, 32'd0);
                chk("R2 paged address", {11'd0, s_addr}, {11'd0, pages[k], 8'(o)});
                chk("R9 R6 read data", s_rd, {16'd0, model({pages[k], 8'(o)})});
                chk("R7 no error in window", {31'd0, s_err}, 32'd0);
            end
            read_page(pages[k], "R3 page kept after data reads");
        end

        set_page(13'h0ABC);
        xfer(1'b0, 24'h040, 1'b1, 32'hFFFF_5A5A);
        chk("R8 strobe", {31'd0, s_wr}, 32'd1);
        chk("R6 R8 wdata", {16'd0, s_wd}, 32'h5A5A);
        chk("R2 write address", {11'd0, s_addr}, {11'd0, 13'h0ABC, 8'h10});
        chk("R9 prdata zero on write", s_rd, 32'd0);
        chk("R8 strobe ends", {31'd0, s_post}, 32'd0);
        xfer(1'b0, 24'h083, 1'b0, 32'd0);
        chk("R5 byte bits ignored", {11'd0, s_addr}, {11'd0, 13'h0ABC, 8'h20});

        xfer(1'b0, 24'h7FC, 1'b1, 32'h0000_0077);
        chk("R7 error flagged", {31'd0, s_err}, 32'd1);
        chk("R7 no strobe", {31'd0, s_wr}, 32'd0);
        xfer(1'b0, 24'h400, 1'b0, 32'd0);
        chk("R7 error read", {31'd0, s_err}, 32'd1);
        chk("R7 rdata zero", s_rd, 32'd0);
        read_page(13'h0ABC, "R3 page kept after error");

        @(negedge clk);
        psel_i = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 24'h3FC; pwdata = 32'h1;
        #1 chk("R10 no strobe", {31'd0, wr_i}, 32'd0);
        chk("R10 no error", {31'd0, pslverr_i}, 32'd0);
        @(negedge clk);
        psel_i = 1'b0; penable = 1'b0;
        read_page(13'h0ABC, "R10 page untouched");

        for (int dv = 0; dv < 32; dv++) begin
            logic [15:0] regs [5];
            regs = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'hFFFF};
            foreach (regs[j]) begin
                logic [20:0] w;
                w = {5'(dv), regs[j]};
                xfer(1'b1, {2'b0, w, 1'b0}, 1'b0, 32'd0);
                chk("R4 direct address", {11'd0, s_addr}, {11'd0, w});
                chk("R9 direct read", s_rd, {16'd0, model(w)});
                xfer(1'b1, {2'b0, w, 1'b1}, 1'b1, {16'd0, regs[j] ^ 16'h3C3C});
                chk("R5 direct byte bit ignored", {11'd0, s_addr}, {11'd0, w});
                chk("R8 direct write", {15'd0, s_wr, s_wd}, {15'd0, 1'b1, regs[j] ^ 16'h3C3C});
            end
        end
        xfer(1'b1, 24'h40_0000, 1'b1, 32'h1234);
        chk("R7 direct error", {30'd0, s_err, s_wr}, 32'd2);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule